// File: doc/BRIEF.md
# Dual-Port Nine-Tap FIR Filter with Cascade Chain

This block is a nine-tap finite impulse response filter. Two 12-bit signed sample streams, a lead port and a follow port, are presented on the same clock. The lead port feeds three taps directly. The follow port feeds six further taps through an internal register delay chain. A 16-bit signed chain input is added to the sum of products, and one 16-bit rounded and saturated chain output is produced on every clock. Several instances can be chained into a longer filter by wiring each chain output to the next chain input.

The nine coefficients are held in three banks of three: a lead, a mid and a tail coefficient per bank. A bank is written through a 2-bit bank select together with three coefficient words. The lead coefficients weight the lead-port taps. The mid coefficients and then the tail coefficients weight progressively older follow-port samples.

Top module: `fir9_dual_chain`

## Requirements
- R1: While `rst_n` is low, `chain_out` is 0 whatever the inputs are. Reset clears all coefficients to 0, so after reset the output carries only the chain input until a bank is written.
- R2: A lead-port sample captured at clock edge j contributes sample×lead(bank 3) to the output after edge j+5, sample×lead(bank 2) after edge j+6, and sample×lead(bank 1) after edge j+7.
- R3: A follow-port sample captured at edge j contributes, after edges j+8, j+9 and j+10, the products with mid(bank 3), mid(bank 2) and mid(bank 1), and after edges j+11, j+12 and j+13 the products with tail(bank 3), tail(bank 2) and tail(bank 1).
- R4: A chain input captured at edge j is added to the output after edge j+4, aligned with the output LSB, so it is scaled by 2^FRAC against the products.
- R5: The output is the full-precision sum of products plus the scaled chain input, divided by 2^FRAC with round-half-up: 2^(FRAC-1) is added, then an arithmetic right shift by FRAC is applied.
- R6: A rounded result above 32767 gives 32767, and one below -32768 gives -32768.
- R7: `wr_bank` encodings: 00 writes nothing, 01 writes bank 1, 10 writes bank 2, 11 writes bank 3. The selected bank takes `wr_lead`, `wr_mid` and `wr_tail` at the clock edge, and the other banks keep their values.
- R8: A new output is produced every clock, and the filter is linear over a continuous stream with no gaps.
- R9: Samples, coefficients, chain input and chain output are two's-complement signed values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| smp_a | input | 12 | Lead-port sample, signed |
| smp_b | input | 12 | Follow-port sample, signed |
| chain_in | input | 16 | Chain input added to the sum, signed |
| wr_bank | input | 2 | Coefficient bank select (00 writes nothing) |
| wr_lead | input | 10 | Lead coefficient for the selected bank, signed |
| wr_mid | input | 10 | Mid coefficient for the selected bank, signed |
| wr_tail | input | 10 | Tail coefficient for the selected bank, signed |
| chain_out | output | 16 | Rounded and saturated filter output, signed |

## Verification
Separate impulses on the lead port, the follow port and the chain input, with all nine coefficients distinct, expose any swapped tap, off-by-one delay or reversed bank order: a wrong design shows a coefficient in the wrong cycle or shows the wrong coefficient. A single-coefficient sweep over every lead-port value covers every fractional pattern, including the exact halves at +128 and -128, so truncation, or rounding halves away from zero, gives an output one step off. Full-scale positive and negative streams drive the sum past both output limits; a design without saturation wraps around to the opposite sign. Writes with bank select 00, and a write to one bank between impulses, show whether a wrong bank is written or a hold is ignored.

// File: rtl/fir9_pkg.sv
package fir9_pkg;

  typedef enum logic [1:0] {
    BANK_NONE  = 2'b00,
    BANK_FIRST = 2'b01,
    BANK_SECND = 2'b10,
    BANK_THIRD = 2'b11
  } bank_sel_e;

  localparam int N_BANK = 3;

  function automatic int imax(input int x, input int y);
    return (x > y) ? x : y;
  endfunction

endpackage

// File: rtl/fir9_coef.sv
module fir9_coef
  import fir9_pkg::*;
#(
  parameter int CW = 10,
  parameter int NB = N_BANK
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [1:0]             sel,
  input  logic [CW-1:0]          lead_wr,
  input  logic [CW-1:0]          mid_wr,
  input  logic [CW-1:0]          tail_wr,
  output logic [NB-1:0][CW-1:0]  k_lead,
  output logic [NB-1:0][CW-1:0]  k_mid,
  output logic [NB-1:0][CW-1:0]  k_tail
);

  logic [NB-1:0]          load_en;
  logic [NB-1:0][CW-1:0]  lead_nx, mid_nx, tail_nx;

  for (genvar g = 0; g < NB; g++) begin : g_bank
    assign load_en[g] = (sel == 2'(g + 1));

    // R7: a bank that is not selected keeps its three coefficients
    p_bank_isolated_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !load_en[g] |=> ($stable(k_lead[g]) && $stable(k_mid[g]) && $stable(k_tail[g])));
  end

  always_comb begin
    for (int b = 0; b < NB; b++) begin
      lead_nx[b] = load_en[b] ? lead_wr : k_lead[b];
      mid_nx[b]  = load_en[b] ? mid_wr  : k_mid[b];
      tail_nx[b] = load_en[b] ? tail_wr : k_tail[b];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      k_lead <= '0;
      k_mid  <= '0;
      k_tail <= '0;
    end else begin
      k_lead <= lead_nx;
      k_mid  <= mid_nx;
      k_tail <= tail_nx;
    end
  end

  // R7: select 00 leaves every coefficient unchanged
  p_hold_all_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == BANK_NONE) |=> ($stable(k_lead) && $stable(k_mid) && $stable(k_tail)));

endmodule

// File: rtl/fir9_taps.sv
module fir9_taps #(
  parameter int DW    = 12,
  parameter int NA    = 3,
  parameter int NBT   = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [DW-1:0]          a_in,
  input  logic [DW-1:0]          b_in,
  output logic [NA-1:0][DW-1:0]  a_taps,
  output logic [NBT-1:0][DW-1:0] b_taps
);

  localparam int B_DEPTH = NA + NBT;

  logic [NA-1:0][DW-1:0]       a_q, a_nx;
  logic [B_DEPTH-1:0][DW-1:0]  b_q, b_nx;

  always_comb begin
    a_nx[0] = a_in;
    for (int i = 1; i < NA; i++) a_nx[i] = a_q[i-1];
    b_nx[0] = b_in;
    for (int i = 1; i < B_DEPTH; i++) b_nx[i] = b_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0;
      b_q <= '0;
    end else begin
      a_q <= a_nx;
      b_q <= b_nx;
    end
  end

  assign a_taps = a_q;
  assign b_taps = b_q[B_DEPTH-1:NA];

endmodule

// File: rtl/fir9_mac.sv
module fir9_mac #(
  parameter int DW    = 12,
  parameter int CW    = 10,
  parameter int OW    = 16,
  parameter int FRAC  = 8,
  parameter int ACC_W = 28,
  parameter int NB    = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NB-1:0][DW-1:0]    a_taps,
  input  logic [2*NB-1:0][DW-1:0]  b_taps,
  input  logic [NB-1:0][CW-1:0]    k_lead,
  input  logic [NB-1:0][CW-1:0]    k_mid,
  input  logic [NB-1:0][CW-1:0]    k_tail,
  input  logic [OW-1:0]            chain_in,
  output logic signed [ACC_W-1:0]  acc
);

  localparam int PW      = DW + CW;
  localparam int NT      = 3 * NB;
  localparam int CH_LAT  = 3;

  logic [DW-1:0]            smp [NT];
  logic [CW-1:0]            cof [NT];
  logic signed [PW-1:0]     prod_nx [NT];
  logic signed [PW-1:0]     prod_q  [NT];
  logic signed [ACC_W-1:0]  grp_nx  [NB];
  logic signed [ACC_W-1:0]  grp_q   [NB];
  logic signed [ACC_W-1:0]  tot_nx, tot_q, acc_nx;
  logic [CH_LAT-1:0][OW-1:0] ch_q, ch_nx;

  // Tap order: newest lead sample with bank 3, then older follow samples
  for (genvar i = 0; i < NB; i++) begin : g_lead
    assign smp[i] = a_taps[i];
    assign cof[i] = k_lead[NB-1-i];
  end
  for (genvar j = 0; j < NB; j++) begin : g_follow
    assign smp[NB+j]   = b_taps[j];
    assign cof[NB+j]   = k_mid[NB-1-j];
    assign smp[2*NB+j] = b_taps[NB+j];
    assign cof[2*NB+j] = k_tail[NB-1-j];
  end

  always_comb begin
    for (int t = 0; t < NT; t++)
      prod_nx[t] = PW'($signed(smp[t])) * PW'($signed(cof[t]));
    for (int g = 0; g < NB; g++) begin
      grp_nx[g] = '0;
      for (int k = 0; k < 3; k++)
        grp_nx[g] = grp_nx[g] + ACC_W'(prod_q[3*g+k]);
    end
    tot_nx = '0;
    for (int g = 0; g < NB; g++) tot_nx = tot_nx + grp_q[g];
    acc_nx = tot_q + (ACC_W'($signed(ch_q[CH_LAT-1])) <<< FRAC);
    ch_nx[0] = chain_in;
    for (int c = 1; c < CH_LAT; c++) ch_nx[c] = ch_q[c-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int t = 0; t < NT; t++) prod_q[t] <= '0;
      for (int g = 0; g < NB; g++) grp_q[g] <= '0;
      tot_q <= '0;
      acc   <= '0;
      ch_q  <= '0;
    end else begin
      for (int t = 0; t < NT; t++) prod_q[t] <= prod_nx[t];
      for (int g = 0; g < NB; g++) grp_q[g] <= grp_nx[g];
      tot_q <= tot_nx;
      acc   <= acc_nx;
      ch_q  <= ch_nx;
    end
  end

endmodule

// File: rtl/fir9_sat.sv
module fir9_sat #(
  parameter int OW    = 16,
  parameter int FRAC  = 8,
  parameter int ACC_W = 28
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic signed [ACC_W-1:0] acc,
  output logic [OW-1:0]           y
);

  localparam logic signed [ACC_W-1:0] ONE    = ACC_W'(1);
  localparam logic signed [ACC_W-1:0] HALF   = ONE <<< (FRAC - 1);
  localparam logic signed [ACC_W-1:0] OMAX   = (ONE <<< (OW - 1)) - ONE;
  localparam logic signed [ACC_W-1:0] OMIN   = -(ONE <<< (OW - 1));
  localparam logic signed [ACC_W-1:0] LIM_HI = (ONE <<< (OW - 1 + FRAC)) - HALF;
  localparam logic signed [ACC_W-1:0] LIM_LO = -(ONE <<< (OW - 1 + FRAC)) - HALF;

  logic signed [ACC_W-1:0] rnd, shf;
  logic [OW-1:0]           y_nx;

  always_comb begin
    rnd = acc + HALF;
    shf = rnd >>> FRAC;
    if (shf > OMAX)      y_nx = OMAX[OW-1:0];
    else if (shf < OMIN) y_nx = OMIN[OW-1:0];
    else                 y_nx = shf[OW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) y <= '0;
    else        y <= y_nx;
  end

  // R6: a sum whose rounded value is past the top clips to the maximum
  p_clip_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc >= LIM_HI) |=> (y == OMAX[OW-1:0]));

  // R6: a sum whose rounded value is past the bottom clips to the minimum
  p_clip_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc < LIM_LO) |=> (y == OMIN[OW-1:0]));

endmodule

// File: rtl/fir9_dual_chain.sv
module fir9_dual_chain
  import fir9_pkg::*;
#(
  parameter int DW   = 12,
  parameter int CW   = 10,
  parameter int OW   = 16,
  parameter int FRAC = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] smp_a,
  input  logic [DW-1:0] smp_b,
  input  logic [OW-1:0] chain_in,
  input  logic [1:0]    wr_bank,
  input  logic [CW-1:0] wr_lead,
  input  logic [CW-1:0] wr_mid,
  input  logic [CW-1:0] wr_tail,
  output logic [OW-1:0] chain_out
);

  localparam int NB    = N_BANK;
  localparam int ACC_W = imax(DW + CW + 4, OW + FRAC + 1) + 2;

  logic [1:0] rst_pipe, rst_pipe_nx;
  logic       core_rst_n;

  assign rst_pipe_nx = {rst_pipe[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= rst_pipe_nx;
  end

  assign core_rst_n = rst_pipe[1];

  logic [NB-1:0][CW-1:0]    k_lead, k_mid, k_tail;
  logic [NB-1:0][DW-1:0]    a_taps;
  logic [2*NB-1:0][DW-1:0]  b_taps;
  logic signed [ACC_W-1:0]  acc;

  fir9_coef #(.CW(CW), .NB(NB)) u_coef (
    .clk     (clk),
    .rst_n   (core_rst_n),
    .sel     (wr_bank),
    .lead_wr (wr_lead),
    .mid_wr  (wr_mid),
    .tail_wr (wr_tail),
    .k_lead  (k_lead),
    .k_mid   (k_mid),
    .k_tail  (k_tail)
  );

  fir9_taps #(.DW(DW), .NA(NB), .NBT(2*NB)) u_taps (
    .clk    (clk),
    .rst_n  (core_rst_n),
    .a_in   (smp_a),
    .b_in   (smp_b),
    .a_taps (a_taps),
    .b_taps (b_taps)
  );

  fir9_mac #(.DW(DW), .CW(CW), .OW(OW), .FRAC(FRAC), .ACC_W(ACC_W), .NB(NB)) u_mac (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .a_taps   (a_taps),
    .b_taps   (b_taps),
    .k_lead   (k_lead),
    .k_mid    (k_mid),
    .k_tail   (k_tail),
    .chain_in (chain_in),
    .acc      (acc)
  );

  fir9_sat #(.OW(OW), .FRAC(FRAC), .ACC_W(ACC_W)) u_sat (
    .clk   (clk),
    .rst_n (core_rst_n),
    .acc   (acc),
    .y     (chain_out)
  );

endmodule

// File: tb/sim_fir9_dual_chain.sv
module sim_fir9_dual_chain;

  localparam int DW = 12, CW = 10, OW = 16, FRAC = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [DW-1:0] smp_a, smp_b;
  logic [OW-1:0] chain_in;
  logic [1:0]    wr_bank;
  logic [CW-1:0] wr_lead, wr_mid, wr_tail;
  logic [OW-1:0] chain_out;

  always #4 clk = ~clk;

  fir9_dual_chain #(.DW(DW), .CW(CW), .OW(OW), .FRAC(FRAC)) u0 (
    .clk(clk), .rst_n(rst_n), .smp_a(smp_a), .smp_b(smp_b), .chain_in(chain_in),
    .wr_bank(wr_bank), .wr_lead(wr_lead), .wr_mid(wr_mid), .wr_tail(wr_tail),
    .chain_out(chain_out)
  );

  int m_lead[3], m_mid[3], m_tail[3];
  int ha[16], hb[16], hc[16];
  int cyc, n_vec, n_bad;

  function automatic longint pa(int i); return (i < 0) ? 0 : longint'(ha[i % 16]); endfunction
  function automatic longint pb(int i); return (i < 0) ? 0 : longint'(hb[i % 16]); endfunction
  function automatic longint pc(int i); return (i < 0) ? 0 : longint'(hc[i % 16]); endfunction

  // Output after edge m from R2, R3, R4, R5, R6
  function automatic int expect_at(int m);
    longint s, r;
    s = pa(m-5)*m_lead[2] + pa(m-6)*m_lead[1] + pa(m-7)*m_lead[0]
      + pb(m-8)*m_mid[2]  + pb(m-9)*m_mid[1]  + pb(m-10)*m_mid[0]
      + pb(m-11)*m_tail[2] + pb(m-12)*m_tail[1] + pb(m-13)*m_tail[0]
      + (pc(m-4) <<< FRAC);
    r = (s + (longint'(1) <<< (FRAC-1))) >>> FRAC;
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return int'(r);
  endfunction

  task automatic check_out(string tag);
    int got, exp;
    got = int'($signed(chain_out));
    exp = expect_at(cyc);
    n_vec++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s at step %0d: got %0d expected %0d", tag, cyc, got, exp);
    end
  endtask

  task automatic step(int a, int b, int c, string tag);
    smp_a = DW'(a); smp_b = DW'(b); chain_in = OW'(c);
    @(posedge clk);
    ha[cyc % 16] = a; hb[cyc % 16] = b; hc[cyc % 16] = c;
    @(negedge clk);
    check_out(tag);
    cyc++;
  endtask

  task automatic load(int bank, int l, int mi, int t, string tag);
    smp_a = '0; smp_b = '0; chain_in = '0;
    wr_bank = 2'(bank); wr_lead = CW'(l); wr_mid = CW'(mi); wr_tail = CW'(t);
    @(posedge clk);
    ha[cyc % 16] = 0; hb[cyc % 16] = 0; hc[cyc % 16] = 0;
    if (bank != 0) begin
      m_lead[bank-1] = l; m_mid[bank-1] = mi; m_tail[bank-1] = t;
    end
    @(negedge clk);
    wr_bank = 2'b00;
    check_out(tag);
    cyc++;
  endtask

  task automatic flush(string tag);
    repeat (14) step(0, 0, 0, tag);
  endtask

  task automatic impulse(int a, int b, int c, string tag);
    step(a, b, c, tag);
    flush(tag);
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got no completion, expected end of run");
    summary();
    $finish;
  end

  initial begin : main
    n_vec = 0; n_bad = 0; cyc = 0;
    for (int i = 0; i < 16; i++) begin ha[i] = 0; hb[i] = 0; hc[i] = 0; end
    for (int i = 0; i < 3; i++) begin m_lead[i] = 0; m_mid[i] = 0; m_tail[i] = 0; end

    // R1: inputs active while reset is held
    rst_n = 1'b0; smp_a = DW'(100); smp_b = DW'(-77); chain_in = OW'(1234);
    wr_bank = 2'b11; wr_lead = CW'(5); wr_mid = CW'(6); wr_tail = CW'(7);
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_vec++;
    if (chain_out != '0) begin
      n_bad++;
      $display("FAIL R1 reset: got %0d expected 0", $signed(chain_out));
    end
    smp_a = '0; smp_b = '0; chain_in = '0; wr_bank = 2'b00;
    wr_lead = '0; wr_mid = '0; wr_tail = '0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: coefficients cleared by reset, only the chain input shows
    impulse(256, 256, 100, "R1");

    // R7: bank loads with nine distinct values
    load(1, 11, -23, 37, "R7");
    load(2, -41, 53, -67, "R7");
    load(3, 79, -97, 101, "R7");
    flush("R7");

    impulse(256, 0, 0, "R2");
    impulse(-512, 0, 0, "R2");
    impulse(0, 256, 0, "R3");
    impulse(0, -256, 0, "R3");
    impulse(0, 0, 321, "R4");
    impulse(0, 0, -5000, "R4");
    impulse(256, 256, 7, "R8");

    // R7: select 00 with new data must not disturb any bank
    load(0, 500, 500, 500, "R7");
    impulse(256, 256, 0, "R7");
    // R7: rewriting bank 2 leaves banks 1 and 3 alone
    load(2, 200, -300, 400, "R7");
    impulse(256, 256, 0, "R7");

    // R5: every lead value through a single unit coefficient
    load(1, 0, 0, 0, "R5");
    load(2, 0, 0, 0, "R5");
    load(3, 1, 0, 0, "R5");
    flush("R5");
    for (int v = -2048; v < 2048; v++) step(v, 0, 0, "R5");
    flush("R5");
    step(128, 0, 0, "R5");
    step(-128, 0, 0, "R5");
    step(127, 0, 0, "R5");
    step(-129, 0, 0, "R5");
    flush("R5");

    // R6: full-scale streams past both limits
    for (int b = 1; b <= 3; b++) load(b, 511, 511, 511, "R6");
    flush("R6");
    repeat (16) step(2047, 2047, 0, "R6");
    repeat (16) step(-2048, -2048, 0, "R6");
    repeat (16) step(2047, 2047, -32768, "R6");
    repeat (16) step(-2048, -2048, 32767, "R6");
    flush("R6");
    for (int b = 1; b <= 3; b++) load(b, -512, -512, -512, "R6");
    flush("R6");
    repeat (16) step(-2048, -2048, 32767, "R6");
    flush("R6");

    // R8 R9: signed random coefficients and continuous random streams
    for (int round = 0; round < 3; round++) begin
      for (int b = 1; b <= 3; b++)
        load(b, int'($urandom_range(0, 1023)) - 512, int'($urandom_range(0, 1023)) - 512,
             int'($urandom_range(0, 1023)) - 512, "R9");
      flush("R9");
      for (int n = 0; n < 1000; n++)
        step(int'($urandom_range(0, 4095)) - 2048, int'($urandom_range(0, 4095)) - 2048,
             int'($urandom_range(0, 65535)) - 32768, "R8 R9");
      flush("R8");
    end

    summary();
    $finish;
  end

endmodule